// File: doc/BRIEF.md
# Wide-to-Narrow Dual-Clock FIFO

This block is a first-in first-out queue that bridges two unrelated clocks and narrows the data path on the way. The producer pushes wide words on the write clock. The consumer pulls words one quarter as wide (by default) on the read clock. Each wide word is handed out as a run of narrow slices, starting with its least significant slice.

Both sides report their own view of the fill level. The write side counts whole wide words and the read side counts narrow words. Each side also raises full or empty and a threshold flag. Each count is taken from that side's own pointer and a Gray-coded copy of the other side's pointer, brought across through a synchronizer chain of configurable length. A freshly written word therefore becomes visible to the reader a few read cycles later.

The read port runs in one of two modes, chosen at build time. In standard mode, an accepted read loads the output register, which shows the word on the next read clock. In look-ahead mode, the oldest word is already on the output whenever empty is low.

Top module: `fifo_w2n_dc`

## Requirements
- R1: Narrow words leave in write order. Each wide word yields RATIO narrow words, taking bits [RD_W-1:0] first and then each higher RD_W-bit slice in ascending order.
- R2: A write presented while full is low is stored. A write presented while full is high stores nothing and leaves the write count unchanged. Full rises on the write that brings the occupancy to WDEPTH wide words.
- R3: A read presented while empty is high removes nothing and leaves the read count at zero. In standard mode the data output keeps its previous value.
- R4: In standard mode, the word removed by an accepted read appears on rd_data one read clock after the read is accepted.
- R5: In look-ahead mode, whenever empty is low, rd_data already carries the oldest unread narrow word. An accepted read advances rd_data to the next word.
- R6: wr_count gives the write-side occupancy in wide words. When WCNT_W is below log2(WDEPTH)+1, it gives the top WCNT_W bits of that occupancy, which is the occupancy shifted right by the difference in width.
- R7: When WCNT_W equals log2(WDEPTH)+1, wr_count steps by one for every wide word written. When WCNT_W is one bit narrower, wr_count steps by one for every two wide words written.
- R8: rd_count gives the read-side occupancy in narrow words, exact at width log2(WDEPTH*RATIO)+1. Once both clocks have run for SYNC_STAGES+2 cycles with no traffic, it equals RATIO times the stored wide words, minus the narrow words already read.
- R9: prog_full is high exactly while the write-side occupancy is at least PFULL_TH. prog_empty is high exactly while the read-side occupancy is at most PEMPTY_TH.
- R10: While rst_n is low, and for the internal release cycles that follow, wr_en and rd_en have no effect. After reset, empty and prog_empty are 1, full and prog_full are 0, both counts are 0 and standard-mode rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized into each domain |
| wr_en | input | 1 | Write request, sampled on wr_clk |
| wr_data | input | WR_W | Wide word to store |
| full | output | 1 | Queue holds WDEPTH wide words |
| prog_full | output | 1 | Write-side occupancy at or above PFULL_TH |
| wr_count | output | WCNT_W | Write-side occupancy in wide words, upper bits if narrowed |
| rd_en | input | 1 | Read request, sampled on rd_clk |
| rd_data | output | WR_W/RATIO | Narrow word out |
| empty | output | 1 | No narrow word available to the reader |
| prog_empty | output | 1 | Read-side occupancy at or below PEMPTY_TH |
| rd_count | output | RCNT_W | Read-side occupancy in narrow words, upper bits if narrowed |

## Verification
Suppose a pointer is damaged or a Gray code is converted wrongly. The first narrow word read after that point comes out of order or duplicated, and the scoreboard catches it on that same read clock. The error also leaves a wrong count or flag once the domains settle. Suppose instead the write-side full compare is off by one. Then either the seventeenth write is accepted, and the check on the write acknowledgement at the port reports it immediately, or full rises one write early. A wrong slice order or a wrong count shift shows up on the first checked word or the first settled count after the fault.

// File: rtl/fifo_w2n_pkg.sv
`timescale 1ns/1ps
package fifo_w2n_pkg;
  typedef logic [31:0] ptr_word_t;

  function automatic ptr_word_t bin2gray(input ptr_word_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_word_t gray2bin(input ptr_word_t g);
    ptr_word_t b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fifo_w2n_sync.sv
`timescale 1ns/1ps
module fifo_w2n_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_w2n_wside.sv
`timescale 1ns/1ps
module fifo_w2n_wside
  import fifo_w2n_pkg::*;
#(
  parameter int          AW    = 4,
  parameter int          RS    = 2,
  parameter int          SYNC  = 2,
  parameter int          CNT_W = 5,
  parameter int unsigned PF_TH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW+RS:0]   rgray_x,
  output logic [AW:0]      wgray,
  output logic [AW-1:0]    waddr,
  output logic             wr_ok,
  output logic             full,
  output logic             prog_full,
  output logic [CNT_W-1:0] count
);
  localparam int PW  = AW + 1;
  localparam int RPW = AW + RS + 1;
  localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [RPW-1:0] rgray_s, rbin_s;
  logic [PW-1:0]  wbin, wbin_nxt, wgray_nxt, rword, occ;

  fifo_w2n_sync #(.W(RPW), .STAGES(SYNC)) u_rptr_sync (
    .clk(clk), .rst_n(rst_n), .d(rgray_x), .q(rgray_s));

  always_comb begin
    rbin_s    = RPW'(gray2bin(32'(rgray_s)));
    rword     = rbin_s[RPW-1:RS];
    occ       = wbin - rword;
    full      = (occ == DEPTH_V);
    prog_full = (32'(occ) >= PF_TH);
    wr_ok     = wr_en & ~full;
    wbin_nxt  = wbin + PW'(wr_ok);
    wgray_nxt = PW'(bin2gray(32'(wbin_nxt)));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_ok) begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
    end

  assign waddr = wbin[AW-1:0];

  if (CNT_W <= PW) begin : g_cnt_trim
    assign count = occ[PW-1 -: CNT_W];
  end else begin : g_cnt_pad
    assign count = {{(CNT_W-PW){1'b0}}, occ};
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wgray));
  assert_wocc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_V);
  assert_wgray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_w2n_rside.sv
`timescale 1ns/1ps
module fifo_w2n_rside
  import fifo_w2n_pkg::*;
#(
  parameter int          AW    = 4,
  parameter int          RS    = 2,
  parameter int          SYNC  = 2,
  parameter int          CNT_W = 7,
  parameter int unsigned PE_TH = 10,
  parameter int          DW    = 8,
  parameter bit          FWFT  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW:0]      wgray_x,
  input  logic [DW-1:0]    head,
  output logic [AW+RS:0]   rgray,
  output logic [AW+RS-1:0] raddr,
  output logic             empty,
  output logic             prog_empty,
  output logic [CNT_W-1:0] count,
  output logic [DW-1:0]    dout
);
  localparam int PW  = AW + 1;
  localparam int RPW = AW + RS + 1;
  localparam logic [RPW-1:0] RDEPTH_V = {1'b1, {(AW+RS){1'b0}}};

  logic [PW-1:0]  wgray_s, wbin_s;
  logic [RPW-1:0] rbin, rbin_nxt, rgray_nxt, wpos, occ;
  logic           rd_ok;

  fifo_w2n_sync #(.W(PW), .STAGES(SYNC)) u_wptr_sync (
    .clk(clk), .rst_n(rst_n), .d(wgray_x), .q(wgray_s));

  always_comb begin
    wbin_s     = PW'(gray2bin(32'(wgray_s)));
    wpos       = {wbin_s, {RS{1'b0}}};
    occ        = wpos - rbin;
    empty      = (occ == '0);
    prog_empty = (32'(occ) <= PE_TH);
    rd_ok      = rd_en & ~empty;
    rbin_nxt   = rbin + RPW'(rd_ok);
    rgray_nxt  = RPW'(bin2gray(32'(rbin_nxt)));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_ok) begin
      rbin  <= rbin_nxt;
      rgray <= rgray_nxt;
    end

  assign raddr = rbin[RPW-2:0];

  if (CNT_W <= RPW) begin : g_cnt_trim
    assign count = occ[RPW-1 -: CNT_W];
  end else begin : g_cnt_pad
    assign count = {{(CNT_W-RPW){1'b0}}, occ};
  end

  if (FWFT) begin : g_lookahead
    assign dout = head;
  end else begin : g_standard
    logic [DW-1:0] dout_q, dout_nxt;
    always_comb dout_nxt = rd_ok ? head : dout_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dout_q <= '0;
      else        dout_q <= dout_nxt;
    assign dout = dout_q;
  end

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(raddr));
  assert_rocc_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= RDEPTH_V);
  assert_rgray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/fifo_w2n_dc.sv
`timescale 1ns/1ps
module fifo_w2n_dc #(
  parameter int          WR_W        = 512,
  parameter int          RATIO       = 4,
  parameter int          WDEPTH      = 512,
  parameter int          SYNC_STAGES = 2,
  parameter int          WCNT_W      = 10,
  parameter int          RCNT_W      = 12,
  parameter int unsigned PFULL_TH    = 10,
  parameter int unsigned PEMPTY_TH   = 10,
  parameter bit          FWFT        = 1'b0
) (
  input  logic                    wr_clk,
  input  logic                    rd_clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WR_W-1:0]         wr_data,
  output logic                    full,
  output logic                    prog_full,
  output logic [WCNT_W-1:0]       wr_count,
  input  logic                    rd_en,
  output logic [WR_W/RATIO-1:0]   rd_data,
  output logic                    empty,
  output logic                    prog_empty,
  output logic [RCNT_W-1:0]       rd_count
);
  localparam int RD_W = WR_W / RATIO;
  localparam int RS   = $clog2(RATIO);
  localparam int AW   = $clog2(WDEPTH);
  localparam int RAW  = AW + RS;

  logic            w_rst_n, r_rst_n, wr_ok;
  logic [AW:0]     wgray;
  logic [RAW:0]    rgray;
  logic [AW-1:0]   waddr;
  logic [RAW-1:0]  raddr;
  logic [WR_W-1:0] mem [WDEPTH];
  logic [WR_W-1:0] head_word;
  logic [RD_W-1:0] head;

  fifo_w2n_sync #(.W(1), .STAGES(2)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(w_rst_n));
  fifo_w2n_sync #(.W(1), .STAGES(2)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(r_rst_n));

  fifo_w2n_wside #(.AW(AW), .RS(RS), .SYNC(SYNC_STAGES), .CNT_W(WCNT_W),
                   .PF_TH(PFULL_TH)) u_wside (
    .clk(wr_clk), .rst_n(w_rst_n), .wr_en(wr_en), .rgray_x(rgray),
    .wgray(wgray), .waddr(waddr), .wr_ok(wr_ok), .full(full),
    .prog_full(prog_full), .count(wr_count));

  always_ff @(posedge wr_clk)
    if (wr_ok) mem[waddr] <= wr_data;

  always_comb begin
    head_word = mem[raddr[RAW-1:RS]];
    head      = head_word[int'(raddr[RS-1:0]) * RD_W +: RD_W];
  end

  fifo_w2n_rside #(.AW(AW), .RS(RS), .SYNC(SYNC_STAGES), .CNT_W(RCNT_W),
                   .PE_TH(PEMPTY_TH), .DW(RD_W), .FWFT(FWFT)) u_rside (
    .clk(rd_clk), .rst_n(r_rst_n), .rd_en(rd_en), .wgray_x(wgray),
    .head(head), .rgray(rgray), .raddr(raddr), .empty(empty),
    .prog_empty(prog_empty), .count(rd_count), .dout(rd_data));
endmodule

// File: tb/fifo_w2n_dc_bench.sv
`timescale 1ns/1ps
module fifo_w2n_dc_bench;
  localparam int WW = 32, RATIO = 4, RW = WW / RATIO, DEPTH = 16;
  localparam int WCW = 4, RCW = 7;

  logic wr_clk = 0, rd_clk = 0, rst_n, wr_en, rd_en;
  logic [WW-1:0] wr_data;
  logic full, prog_full, empty, prog_empty;
  logic full_f, prog_full_f, empty_f, prog_empty_f;
  logic [WCW-1:0] wr_count, wr_count_f;
  logic [RCW-1:0] rd_count, rd_count_f;
  logic [RW-1:0] std_dout, fwft_dout;

  always #10 wr_clk = ~wr_clk;
  always #7  rd_clk = ~rd_clk;

  fifo_w2n_dc #(.WR_W(WW), .RATIO(RATIO), .WDEPTH(DEPTH), .SYNC_STAGES(2),
    .WCNT_W(WCW), .RCNT_W(RCW), .PFULL_TH(10), .PEMPTY_TH(10), .FWFT(1'b0))
  u_fifo_w2n_dc (.wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .full(full), .prog_full(prog_full), .wr_count(wr_count),
    .rd_en(rd_en), .rd_data(std_dout), .empty(empty), .prog_empty(prog_empty),
    .rd_count(rd_count));

  fifo_w2n_dc #(.WR_W(WW), .RATIO(RATIO), .WDEPTH(DEPTH), .SYNC_STAGES(2),
    .WCNT_W(WCW), .RCNT_W(RCW), .PFULL_TH(10), .PEMPTY_TH(10), .FWFT(1'b1))
  u_fifo_w2n_dc_fwft (.wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .full(full_f), .prog_full(prog_full_f), .wr_count(wr_count_f),
    .rd_en(rd_en), .rd_data(fwft_dout), .empty(empty_f), .prog_empty(prog_empty_f),
    .rd_count(rd_count_f));

  int n_tests = 0, n_fail = 0, wcnt = 0, rd_left = 0, rd_mode = 0;
  bit started = 0, done = 0, prev_acc = 0;
  logic [RW-1:0] sb[$];
  logic [RW-1:0] prev_exp, std_last, exp_w;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [WW-1:0] mk_word(input int k);
    logic [WW-1:0] w;
    for (int s = 0; s < RATIO; s++) w[s*RW +: RW] = RW'(k * RATIO + s);
    return w;
  endfunction

  task automatic push_word(output bit acc);
    @(negedge wr_clk);
    wr_data = mk_word(wcnt);
    wr_en   = 1'b1;
    acc     = !full;
    if (acc) begin
      for (int s = 0; s < RATIO; s++) sb.push_back(wr_data[s*RW +: RW]);
      wcnt++;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge rd_clk);
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic rd_request(input int n);
    rd_left = n;
    rd_mode = 1;
    wait (rd_left == 0);
    @(negedge rd_clk);
    @(negedge rd_clk);
    rd_mode = 0;
  endtask

  // scoreboard monitor and read driver
  always @(negedge rd_clk) if (started) begin
    if (prev_acc) chk(std_dout == prev_exp, "R4 std data one cycle late", std_dout, prev_exp);
    else          chk(std_dout == std_last, "R3 std data holds", std_dout, std_last);
    std_last = std_dout;
    prev_acc = 1'b0;
    case (rd_mode)
      0:       rd_en = 1'b0;
      1:       rd_en = (rd_left > 0);
      2:       rd_en = ($urandom % 3) != 0;
      default: rd_en = 1'b1;
    endcase
    if (rd_en && !empty) begin
      if (sb.size() == 0) chk(1'b0, "R1 read with no stored word", fwft_dout, 0);
      else begin
        exp_w = sb.pop_front();
        chk(fwft_dout == exp_w, "R5 R1 look-ahead head in order", fwft_dout, exp_w);
        prev_exp = exp_w;
        prev_acc = 1'b1;
      end
      if (rd_mode == 1) rd_left--;
    end
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    rst_n = 0; wr_en = 1; rd_en = 1; wr_data = '1;
    repeat (6) @(negedge wr_clk);
    wr_en = 0; rd_en = 0; rst_n = 1;
    settle();
    // R10: reset state, enables during reset ignored
    chk(empty == 1, "R10 empty after reset", empty, 1);
    chk(full == 0, "R10 full after reset", full, 0);
    chk(wr_count == 0, "R10 wr_count after reset", wr_count, 0);
    chk(rd_count == 0, "R10 rd_count after reset", rd_count, 0);
    chk(prog_empty == 1 && prog_full == 0, "R10 threshold flags after reset",
        {prog_empty, prog_full}, 2'b10);
    chk(std_dout == 0, "R10 std data after reset", std_dout, 0);
    std_last = std_dout;
    started = 1;

    // three words, then counts
    for (int i = 0; i < 3; i++) push_word(a);
    settle();
    chk(wr_count == 1, "R7 R6 narrowed count 3 words", wr_count, 1);
    chk(rd_count == 12, "R8 rd_count 3 words", rd_count, 12);
    chk(prog_empty == 0, "R9 prog_empty above threshold", prog_empty, 0);
    chk(fwft_dout == sb[0], "R5 head visible before read", fwft_dout, sb[0]);
    rd_request(12);
    settle();
    chk(empty == 1 && rd_count == 0, "R8 drained", rd_count, 0);
    chk(wr_count == 0, "R6 wr_count drained", wr_count, 0);

    // fill past full
    for (int i = 1; i <= 20; i++) begin
      push_word(a);
      if (i == 2)  chk(wr_count == 1, "R7 count steps per two words", wr_count, 1);
      if (i == 9)  chk(prog_full == 0, "R9 prog_full at 9", prog_full, 0);
      if (i == 10) chk(prog_full == 1, "R9 prog_full at 10", prog_full, 1);
      if (i == 15) chk(full == 0, "R2 not full at 15", full, 0);
      if (i == 16) chk(full == 1, "R2 full at 16", full, 1);
      if (i > 16)  chk(a == 0, "R2 write while full ignored", a, 0);
    end
    chk(wr_count == 8, "R6 narrowed count when full", wr_count, 8);
    chk(sb.size() == 64, "R2 stored narrow words", sb.size(), 64);
    settle();
    chk(rd_count == 64, "R8 rd_count full", rd_count, 64);
    rd_request(53);
    chk(rd_count == 11 && prog_empty == 0, "R9 prog_empty at 11", {rd_count, prog_empty}, {7'd11, 1'b0});
    rd_request(1);
    chk(rd_count == 10 && prog_empty == 1, "R9 prog_empty at 10", {rd_count, prog_empty}, {7'd10, 1'b1});
    rd_request(10);
    settle();
    chk(empty == 1 && full == 0, "R2 R1 drained after full", {empty, full}, 2'b10);

    // reads while empty
    rd_mode = 3;
    repeat (8) @(negedge rd_clk);
    rd_mode = 0;
    chk(rd_count == 0, "R3 rd_count stays zero", rd_count, 0);

    // concurrent traffic
    rd_mode = 2;
    for (int i = 0; i < 80; i++) begin
      repeat ($urandom % 3) @(negedge wr_clk);
      do push_word(a); while (!a);
    end
    rd_mode = 3;
    wait (sb.size() == 0);
    settle();
    rd_mode = 0;
    settle();
    chk(empty == 1 && rd_count == 0, "R1 R8 empty after stream", rd_count, 0);
    chk(wr_count == 0 && full == 0, "R6 wr side empty after stream", wr_count, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule